// File: doc/BRIEF.md
# Atomic Bit Test-and-Clear Unit

This block carries out a single-bit test-and-clear on a 32-bit word. A request names a bit position (0 to 31) and a target. The target is either a word in external memory, reached through a simple synchronous port, or the block's own status register. The unit reads the target and copies the chosen bit into the carry flag. It then writes the word back with that bit forced to 0 and every other bit unchanged.

For a memory target the work is one read followed by one write to the same address. A lock output covers both accesses, so a bus arbiter cannot hand the memory to another master in between. This is what lets several processors use the operation as a semaphore on shared memory. For a status-register target no memory access is made. Bits 0 to 7 of that register hold the condition flags, with the carry flag in bit 0. Clearing one of those bits therefore clears the matching flag.

The surrounding core updates the status register through a flag-load path. That path is only honoured while the unit is idle.

Top module: `tstclr_unit`

## Requirements
- R1: `op_bit` selects any bit position from 0 to 31 of the target word. The position is captured when the request is accepted.
- R2: For a memory target, the carry flag (`status[0]`) holds the old value of the selected memory bit once `done` is high. All other status bits are unchanged.
- R3: For a memory target, the word written equals the word read with only the selected bit cleared.
- R4: A memory operation makes exactly one read (`mem_rd`) in the cycle after acceptance and exactly one write (`mem_wr`) in the next cycle, both to the captured address. The read data is taken one cycle after `mem_rd`. A status-register operation makes no memory access.
- R5: `mem_lock` is high in both access cycles of a memory operation and low in every other cycle.
- R6: The sequence is idle, read, write, done. `busy` is high for the three cycles from acceptance, and `done` is a one-cycle pulse in the third of them.
- R7: A request arriving while `busy` is high is ignored. The operation in flight keeps its captured index, address and target.
- R8: For a status-register target with index n ≥ 1, bit n is cleared, the carry flag takes the old bit n, and all other bits keep their values.
- R9: For a status-register target with index 0, the carry flag ends at 0 whatever its earlier value.
- R10: `flag_we` loads `flag_wdata` into the status register on the next edge when `busy` is low. It is ignored while `busy` is high.
- R11: Reset sets the status register (and so the carry flag) to 0, and leaves `busy`, `done`, `mem_rd`, `mem_wr` and `mem_lock` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_to_status | input | 1 | 1: target is the status register, 0: memory |
| req_bit | input | 5 | Bit index to test and clear |
| req_addr | input | 16 | Memory word address |
| flag_we | input | 1 | Status register load strobe |
| flag_wdata | input | 32 | Status register load value |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe (data one cycle later) |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_lock | output | 1 | Bus lock over the read-write pair |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Status register; bit 0 is the carry flag |

## Verification
The hardest case to reach is an operation whose inputs change while it is running. A fresh request and a flag load may both arrive during the read, write and done cycles. Neither may alter the captured address, index or target, nor the status result. The random stimulus drives such an intruding request with a different address, index and target on about a third of the operations. It asserts a flag load in the same window. The status-register case at index 0 with the carry already set is also reached on purpose: a flag load sets the carry first, then the operation runs.

// File: rtl/tstclr_pkg.sv
`timescale 1ns/1ps
package tstclr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } tc_state_e;
endpackage

// File: rtl/tstclr_mask.sv
`timescale 1ns/1ps
// One-hot decode of the bit index, one comparator per bit position.
module tstclr_mask #(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] onehot
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign onehot[g] = (idx == IW'(g));
  end
endmodule

// File: rtl/tstclr_ctrl.sv
`timescale 1ns/1ps
// Sequencer: idle -> read -> write -> done -> idle.
module tstclr_ctrl
  import tstclr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic accept,
  output logic busy,
  output logic done,
  output logic in_read,
  output logic in_write
);
  tc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign in_read  = (state_q == ST_READ);
  assign in_write = (state_q == ST_WRITE);
endmodule

// File: rtl/tstclr_opreg.sv
`timescale 1ns/1ps
// Holds the operation fields captured at acceptance.
module tstclr_opreg #(
  parameter int AW = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [IW-1:0] req_bit,
  input  logic [AW-1:0] req_addr,
  input  logic          req_to_status,
  output logic [IW-1:0] op_bit,
  output logic [AW-1:0] op_addr,
  output logic          op_sr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_bit  <= '0;
      op_addr <= '0;
      op_sr   <= 1'b0;
    end else if (accept) begin
      op_bit  <= req_bit;
      op_addr <= req_addr;
      op_sr   <= req_to_status;
    end
  end
endmodule

// File: rtl/tstclr_statreg.sv
`timescale 1ns/1ps
// Status register with the carry flag in bit 0.
module tstclr_statreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_we,
  input  logic [DW-1:0] flag_wdata,
  input  logic          busy,
  input  logic          commit,
  input  logic          op_sr,
  input  logic [DW-1:0] sel_mask,
  input  logic          mem_bit,
  output logic [DW-1:0] sr_q
);
  // Result of one test-and-clear on the status register. The carry first
  // takes the tested bit; if bit 0 itself is the target, the clear wins.
  function automatic logic [DW-1:0] sr_after(
    input logic [DW-1:0] cur,
    input logic [DW-1:0] m,
    input logic          from_sr,
    input logic          mbit
  );
    logic [DW-1:0] r;
    logic          tested;
    tested = from_sr ? |(cur & m) : mbit;
    r      = from_sr ? (cur & ~m) : cur;
    r[0]   = (from_sr && m[0]) ? 1'b0 : tested;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                sr_q <= '0;
    else if (commit)           sr_q <= sr_after(sr_q, sel_mask, op_sr, mem_bit);
    else if (flag_we && !busy) sr_q <= flag_wdata;
  end
endmodule

// File: rtl/tstclr_unit.sv
`timescale 1ns/1ps
module tstclr_unit #(
  parameter int DW = 32,
  parameter int AW = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_to_status,
  input  logic [IW-1:0] req_bit,
  input  logic [AW-1:0] req_addr,
  input  logic          flag_we,
  input  logic [DW-1:0] flag_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_lock,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] status
);
  logic          accept, in_read, in_write;
  logic [IW-1:0] op_bit;
  logic [AW-1:0] op_addr;
  logic          op_sr;
  logic [DW-1:0] sel_mask;
  logic          mem_bit;
  // Named events for the checker
  logic          ev_sr_bit0_done;

  tstclr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .accept(accept),
    .busy(busy), .done(done), .in_read(in_read), .in_write(in_write)
  );

  tstclr_opreg #(.AW(AW), .IW(IW)) u_opreg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_bit(req_bit),
    .req_addr(req_addr), .req_to_status(req_to_status),
    .op_bit(op_bit), .op_addr(op_addr), .op_sr(op_sr)
  );

  tstclr_mask #(.DW(DW), .IW(IW)) u_mask (.idx(op_bit), .onehot(sel_mask));

  tstclr_statreg #(.DW(DW)) u_sr (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .busy(busy), .commit(in_write), .op_sr(op_sr), .sel_mask(sel_mask),
    .mem_bit(mem_bit), .sr_q(status)
  );

  assign mem_bit   = |(mem_rdata & sel_mask);
  assign mem_addr  = op_addr;
  assign mem_rd    = in_read  && !op_sr;
  assign mem_wr    = in_write && !op_sr;
  assign mem_wdata = mem_rdata & ~sel_mask;
  assign mem_lock  = (in_read || in_write) && !op_sr;

  assign ev_sr_bit0_done = done && op_sr && (op_bit == '0);
endmodule

// File: rtl/tstclr_chk.sv
`timescale 1ns/1ps
module tstclr_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_lock,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          busy,
  input logic          done,
  input logic          flag_we,
  input logic [DW-1:0] status,
  input logic          ev_sr_bit0_done
);
  p_lock_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> mem_lock);
  p_lock_only_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> (mem_rd || mem_wr));
  p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && mem_addr == $past(mem_addr)));
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  p_no_dual_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
  p_single_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (((mem_wdata & ~mem_rdata) == '0) &&
                ($countones(mem_wdata ^ mem_rdata) <= 1)));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_access_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);
  p_carry_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sr_bit0_done |-> !status[0]);
  p_sr_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !flag_we) |=> $stable(status));
endmodule

bind tstclr_unit tstclr_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .busy(busy), .done(done), .flag_we(flag_we),
  .status(status), .ev_sr_bit0_done(ev_sr_bit0_done)
);

// File: tb/tstclr_unit_tb_top.sv
`timescale 1ns/1ps
module tstclr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_to_status = 1'b0;
  logic [4:0]  req_bit = '0;
  logic [15:0] req_addr = '0;
  logic        flag_we = 1'b0;
  logic [31:0] flag_wdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, mem_lock, busy, done;
  logic [31:0] mem_wdata, status;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  tstclr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_to_status(req_to_status),
    .req_bit(req_bit), .req_addr(req_addr), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_lock(mem_lock), .busy(busy), .done(done),
    .status(status)
  );

  // Synchronous memory model, 64 words
  logic [31:0] mem_m [64];
  int rd_cnt = 0, wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= mem_m[mem_addr[5:0]]; rd_cnt++; end
    if (mem_wr) begin mem_m[mem_addr[5:0]] <= mem_wdata; wr_cnt++; end
  end

  int vecs = 0, fails = 0;
  logic [31:0] sr_m = '0;
  bit finished = 0;

  function automatic logic [31:0] knock_out(input logic [31:0] w, input int b);
    logic [31:0] r = w;
    r[b] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] sr_model(input logic [31:0] sr, input bit to_sr,
                                           input int b, input logic [31:0] word);
    logic [31:0] r;
    if (to_sr) begin
      r = knock_out(sr, b);
      r[0] = (b == 0) ? 1'b0 : sr[b];
    end else begin
      r = sr;
      r[0] = word[b];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flag_load(input logic [31:0] v);
    flag_we = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_we = 1'b0;
    chk(status == v, "R10 flag load while idle", status, v);
    sr_m = v;
  endtask

  task automatic run_op(input bit to_sr, input logic [5:0] a, input logic [4:0] b,
                        input bit intrude);
    logic [31:0] old_w, exp_w, exp_sr;
    int rd0, wr0;
    old_w  = mem_m[a];
    exp_w  = to_sr ? old_w : knock_out(old_w, b);
    exp_sr = sr_model(sr_m, to_sr, int'(b), old_w);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_to_status = to_sr; req_addr = {10'd0, a}; req_bit = b;
    @(negedge clk);                               // read cycle
    req_valid = intrude;
    if (intrude) begin                            // R7 stray request, R10 stray load
      req_to_status = ~to_sr; req_addr = {10'd0, a ^ 6'h2b}; req_bit = ~b;
      flag_we = 1'b1; flag_wdata = $urandom;
    end
    chk(busy && !done, "R6 busy in read cycle", {30'd0, busy, done}, 32'h2);
    chk(mem_rd == !to_sr, "R4 read strobe", {31'd0, mem_rd}, {31'd0, !to_sr});
    chk(mem_lock == !to_sr, "R5 lock in read", {31'd0, mem_lock}, {31'd0, !to_sr});
    if (!to_sr) chk(mem_addr == {10'd0, a}, "R4 read address", {16'd0, mem_addr}, {26'd0, a});
    @(negedge clk);                               // write cycle
    chk(mem_wr == !to_sr && !mem_rd, "R4 write strobe", {30'd0, mem_rd, mem_wr}, {31'd0, !to_sr});
    chk(mem_lock == !to_sr, "R5 lock in write", {31'd0, mem_lock}, {31'd0, !to_sr});
    if (!to_sr) begin
      chk(mem_addr == {10'd0, a}, "R7 captured address", {16'd0, mem_addr}, {26'd0, a});
      chk(mem_wdata == exp_w, "R3 write data", mem_wdata, exp_w);
    end
    @(negedge clk);                               // done cycle
    chk(done && busy && !mem_lock, "R6 done pulse", {29'd0, mem_lock, busy, done}, 32'h3);
    chk(status[0] == exp_sr[0], to_sr ? (b == 0 ? "R9 carry after bit0" : "R8 carry") : "R2 carry",
        {31'd0, status[0]}, {31'd0, exp_sr[0]});
    chk(status == exp_sr, to_sr ? "R8 status result" : "R2 status untouched", status, exp_sr);
    chk(mem_m[a] == exp_w, "R1 memory word", mem_m[a], exp_w);
    chk((rd_cnt - rd0) == (to_sr ? 0 : 1) && (wr_cnt - wr0) == (to_sr ? 0 : 1),
        "R4 access count", rd_cnt - rd0, to_sr ? 0 : 1);
    req_valid = 1'b0; flag_we = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_lock, "R6 back to idle", {29'd0, mem_lock, busy, done}, 32'h0);
    sr_m = exp_sr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 64; i++) mem_m[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 32'd0, "R11 status after reset", status, 32'd0);
    chk(!busy && !done && !mem_rd && !mem_wr && !mem_lock, "R11 idle after reset",
        {27'd0, busy, done, mem_rd, mem_wr, mem_lock}, 32'd0);

    // Directed corner cases
    mem_m[5] = 32'h8000_0001;
    run_op(1'b0, 6'd5, 5'd31, 1'b0);              // R1 top bit, carry 1
    run_op(1'b0, 6'd5, 5'd0, 1'b0);               // R1 bottom bit
    run_op(1'b0, 6'd5, 5'd0, 1'b0);               // bit already clear -> carry 0
    flag_load(32'hFFFF_FFFF);
    run_op(1'b1, 6'd0, 5'd0, 1'b0);               // R9 carry set, bit0 target
    run_op(1'b1, 6'd0, 5'd5, 1'b0);               // R8 carry from bit 5
    run_op(1'b1, 6'd0, 5'd5, 1'b1);               // R8 bit now 0, R7 intrusion
    run_op(1'b0, 6'd9, 5'd17, 1'b1);              // R7 intrusion on memory op

    // Random mix
    for (int k = 0; k < 400; k++) begin
      bit to_sr;
      to_sr = ($urandom % 4) == 0;
      if (to_sr && ($urandom % 2) == 0) flag_load($urandom);
      run_op(to_sr, 6'($urandom), 5'($urandom), ($urandom % 3) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule